// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Masking

This block watches a running BCD calendar and raises an alarm when the calendar reaches a programmed minute, hour, day of month and weekday. Each of the four alarm fields can be left out of the comparison on its own, so the same hardware covers a daily, weekly or monthly alarm. The comparison runs only on the strobe that the timekeeper sends when the minute rolls over, so the alarm has one-minute resolution.

Software reaches the block through a small byte-wide register bus. Four alarm registers hold the programmed field values, each with a disable bit. A control byte holds the sticky alarm flag and the interrupt enable. When the flag and the enable are both set, an active-low interrupt output stays low until software clears the flag.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the control byte reads 0x00, `irq_n` is 1 and every alarm register reads 0x80, so every field starts out disabled.
- R2: The alarm registers for minute, hour, day of month and weekday sit at addresses 0x09, 0x0A, 0x0B and 0x0C. A write stores all 8 bits and a read on the next cycle returns them.
- R3: The control byte sits at address 0x01. Bit 3 is the alarm flag and bit 1 is the interrupt enable. All its other bits read 0, and any address that is not mapped reads 0x00.
- R4: When `min_tick` is high at a clock edge and every enabled field equals its calendar value, the flag reads 1 after that edge. The compare covers minute bits 6:0, hour bits 5:0, day bits 5:0 and weekday bits 2:0.
- R5: When bit 7 of an alarm register is 1, that field is left out of the match. Only the enabled fields have to be equal.
- R6: The flag is never set by a mismatching calendar, and never set when `min_tick` is low, even if the calendar matches.
- R7: When all four alarm registers have bit 7 set, no alarm is generated.
- R8: `irq_n` is 0 exactly when the flag and the interrupt enable are both 1. It follows a change of either bit in the same cycle that the control byte shows it.
- R9: Writing the control byte with bit 3 at 0 clears the flag. Writing it with bit 3 at 1 leaves the flag unchanged. Bit 1 is always taken from the written data.
- R10: A match sets the flag even when the interrupt enable is 0, so software can poll for it.
- R11: If a write clears the flag in the same cycle as a matching tick, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cal_min | input | 7 | Current BCD minute |
| cal_hour | input | 6 | Current BCD hour |
| cal_mday | input | 6 | Current BCD day of month |
| cal_wday | input | 3 | Current weekday |
| min_tick | input | 1 | One-cycle strobe at each minute boundary |
| irq_n | output | 1 | Alarm interrupt, active low, level |

## Verification
Register writes and calendar ticks are both taken at one clock edge. Their effects are therefore due on the first edge after the stimulus: the new register value, the flag and the interrupt level all appear there, and `bus_rdata` and `irq_n` follow those registers with no further delay. The driver applies each stimulus at a falling edge and holds it for exactly one rising edge. It then queues the expected read data and interrupt level at the next falling edge, after the address has settled. The monitor compares them at that point, half a cycle away from any active edge.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int NUM_FIELDS = 4;
    localparam int VAL_W      = DATA_W - 1;
    localparam int IDX_W      = $clog2(NUM_FIELDS);

    localparam int OFF_BIT  = DATA_W - 1;
    localparam int FLAG_BIT = 3;
    localparam int IEN_BIT  = 1;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_FBASE = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_FLAST = ADR_FBASE + ADDR_W'(NUM_FIELDS - 1);

    typedef enum logic [IDX_W-1:0] {
        FLD_MIN  = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_MDAY = 2'd2,
        FLD_WDAY = 2'd3
    } field_e;

    typedef struct packed {
        logic             off;
        logic [VAL_W-1:0] val;
    } alarm_field_t;

    localparam alarm_field_t FIELD_RST = '{off: 1'b1, val: '0};

    // significant calendar bits of each field
    function automatic logic [VAL_W-1:0] field_mask(input int idx);
        case (idx)
            int'(FLD_MIN):  return 7'h7F;
            int'(FLD_HOUR): return 7'h3F;
            int'(FLD_MDAY): return 7'h3F;
            default:        return 7'h07;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_byte(input logic flag, input logic ien);
        logic [DATA_W-1:0] b;
        b           = '0;
        b[FLAG_BIT] = flag;
        b[IEN_BIT]  = ien;
        return b;
    endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import rtc_alarm_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    output alarm_field_t [NUM_FIELDS-1:0]      fields
);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [ADDR_W-1:0] MY_ADDR = ADR_FBASE + ADDR_W'(i);

        always_ff @(posedge clk) begin
            if (rst)
                fields[i] <= FIELD_RST;
            else if (we && addr == MY_ADDR)
                fields[i] <= alarm_field_t'(wdata);
        end

        // R2
        field_store_chk: assert property (@(posedge clk) disable iff (rst)
            (we && addr == MY_ADDR) |=> (fields[i] == $past(wdata)));
    end

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import rtc_alarm_pkg::*;
(
    input  alarm_field_t [NUM_FIELDS-1:0]            fields,
    input  logic [NUM_FIELDS-1:0][VAL_W-1:0]         cal,
    input  logic                                     min_tick,
    output logic                                     set_req
);

    logic [NUM_FIELDS-1:0] hit;
    logic [NUM_FIELDS-1:0] live;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        localparam logic [VAL_W-1:0] MASK = field_mask(i);
        assign live[i] = ~fields[i].off;
        assign hit[i]  = fields[i].off |
                         ((fields[i].val & MASK) == (cal[i] & MASK));
    end

    assign set_req = min_tick & (|live) & (&hit);

endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_req,
    output logic              flag,
    output logic              ien,
    output logic              irq_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            ien  <= 1'b0;
        end else begin
            if (ctrl_we)
                ien <= wdata[IEN_BIT];
            if (set_req)
                flag <= 1'b1;
            else if (ctrl_we && !wdata[FLAG_BIT])
                flag <= 1'b0;
        end
    end

    assign irq_n = ~(flag & ien);

    // R9
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(ctrl_we && !wdata[FLAG_BIT]));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> flag);

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic [5:0]        cal_mday,
    input  logic [2:0]        cal_wday,
    input  logic              min_tick,
    output logic              irq_n
);

    alarm_field_t [NUM_FIELDS-1:0]    fields;
    logic [NUM_FIELDS-1:0][VAL_W-1:0] cal;
    logic                             set_req;
    logic                             flag;
    logic                             ien;
    logic                             ctrl_we;
    logic [ADDR_W-1:0]                rel_addr;

    assign ctrl_we = bus_we && (bus_addr == ADR_CTRL);

    always_comb begin
        cal           = '0;
        cal[FLD_MIN]  = cal_min;
        cal[FLD_HOUR] = VAL_W'(cal_hour);
        cal[FLD_MDAY] = VAL_W'(cal_mday);
        cal[FLD_WDAY] = VAL_W'(cal_wday);
    end

    alarm_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .fields (fields)
    );

    alarm_compare u_cmp (
        .fields   (fields),
        .cal      (cal),
        .min_tick (min_tick),
        .set_req  (set_req)
    );

    alarm_flag_ctl u_flag (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (ctrl_we),
        .wdata   (bus_wdata),
        .set_req (set_req),
        .flag    (flag),
        .ien     (ien),
        .irq_n   (irq_n)
    );

    assign rel_addr = bus_addr - ADR_FBASE;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL)
            bus_rdata = ctrl_byte(flag, ien);
        else if (bus_addr >= ADR_FBASE && bus_addr <= ADR_FLAST)
            bus_rdata = fields[rel_addr[IDX_W-1:0]];
    end

    // R4
    flag_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(set_req));

    // R7
    all_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fields[0].off && fields[1].off && fields[2].off && fields[3].off) |-> !set_req);

    // R8
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> ($past(set_req) || $past(ctrl_we && bus_wdata[IEN_BIT])));

endmodule

// File: tb/rtc_alarm_match_bench.sv
`timescale 1ns/1ps
module rtc_alarm_match_bench;

    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] cal_min = '0;
    logic [5:0] cal_hour = '0;
    logic [5:0] cal_mday = '0;
    logic [2:0] cal_wday = '0;
    logic       min_tick = 1'b0;
    logic       irq_n;

    always #(HALF) clk = ~clk;

    rtc_alarm_match u_rtc_alarm_match (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cal_min(cal_min),
        .cal_hour(cal_hour), .cal_mday(cal_mday), .cal_wday(cal_wday),
        .min_tick(min_tick), .irq_n(irq_n)
    );

    typedef struct {
        logic [3:0] addr;
        logic [7:0] rd;
        logic       irq;
        int         req;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (bus_rdata !== e.rd || irq_n !== e.irq) begin
                    fails++;
                    $display("FAIL R%0d addr=0x%0h: rdata=0x%02h irq_n=%b, expected rdata=0x%02h irq_n=%b",
                             e.req, e.addr, bus_rdata, irq_n, e.rd, e.irq);
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic set_cal(input logic [6:0] mn, input logic [5:0] hr,
                           input logic [5:0] dy, input logic [2:0] wd);
        cal_min = mn; cal_hour = hr; cal_mday = dy; cal_wday = wd;
    endtask

    task automatic tick(input logic [6:0] mn, input logic [5:0] hr,
                        input logic [5:0] dy, input logic [2:0] wd);
        @(negedge clk);
        set_cal(mn, hr, dy, wd);
        min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
    endtask

    // driver: sets the read address, queues the expectation, triggers the monitor
    task automatic expect_rd(input logic [3:0] a, input logic [7:0] rd,
                             input logic irq, input int req);
        exp_t e;
        @(negedge clk);
        bus_addr = a;
        #1;
        e.addr = a; e.rd = rd; e.irq = irq; e.req = req;
        q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL R0 watchdog: run did not complete, expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(4'h1, 8'h00, 1'b1, 1);
        expect_rd(4'h9, 8'h80, 1'b1, 1);
        expect_rd(4'hC, 8'h80, 1'b1, 1);

        // R2 alarm register storage
        bus_write(4'h9, 8'h30);
        bus_write(4'hA, 8'h12);
        bus_write(4'hB, 8'h80);
        bus_write(4'hC, 8'h80);
        expect_rd(4'h9, 8'h30, 1'b1, 2);
        expect_rd(4'hA, 8'h12, 1'b1, 2);
        bus_write(4'hB, 8'h5A);
        expect_rd(4'hB, 8'h5A, 1'b1, 2);
        bus_write(4'hB, 8'h80);

        // R3 control byte layout: 0xFF keeps flag 0, sets enable, others read 0
        bus_write(4'h1, 8'hFF);
        expect_rd(4'h1, 8'h02, 1'b1, 3);
        expect_rd(4'h5, 8'h00, 1'b1, 3);

        // R6 mismatch on tick
        tick(7'h29, 6'h12, 6'h05, 3'd3);
        expect_rd(4'h1, 8'h02, 1'b1, 6);

        // R4 R5 R8 match with day and weekday masked
        tick(7'h30, 6'h12, 6'h05, 3'd3);
        expect_rd(4'h1, 8'h0A, 1'b0, 4);

        // R9 writing 1 to the flag keeps it
        bus_write(4'h1, 8'h0A);
        expect_rd(4'h1, 8'h0A, 1'b0, 9);

        // R8 dropping the enable releases irq, flag remains
        bus_write(4'h1, 8'h08);
        expect_rd(4'h1, 8'h08, 1'b1, 8);

        // R9 writing 0 clears
        bus_write(4'h1, 8'h00);
        expect_rd(4'h1, 8'h00, 1'b1, 9);

        // R6 matching calendar without tick
        @(negedge clk);
        set_cal(7'h30, 6'h12, 6'h05, 3'd3);
        repeat (2) @(negedge clk);
        expect_rd(4'h1, 8'h00, 1'b1, 6);

        // R10 match while enable is 0
        tick(7'h30, 6'h12, 6'h07, 3'd1);
        expect_rd(4'h1, 8'h08, 1'b1, 10);

        // R11 clearing write collides with a matching tick
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'h1; bus_wdata = 8'h00;
        min_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; min_tick = 1'b0;
        expect_rd(4'h1, 8'h08, 1'b1, 11);

        // R7 all four fields disabled
        bus_write(4'h1, 8'h02);
        bus_write(4'h9, 8'h80);
        bus_write(4'hA, 8'h80);
        tick(7'h30, 6'h12, 6'h05, 3'd3);
        expect_rd(4'h1, 8'h02, 1'b1, 7);

        // R5 weekday only: other calendar fields are ignored
        bus_write(4'hC, 8'h03);
        tick(7'h59, 6'h23, 6'h31, 3'd2);
        expect_rd(4'h1, 8'h02, 1'b1, 5);
        tick(7'h59, 6'h23, 6'h31, 3'd3);
        expect_rd(4'h1, 8'h0A, 1'b0, 5);

        // R8 interrupt held until flag cleared
        repeat (4) @(negedge clk);
        expect_rd(4'h1, 8'h0A, 1'b0, 8);
        bus_write(4'h1, 8'h02);
        expect_rd(4'h1, 8'h02, 1'b1, 8);

        done = 1'b1;
        finish_up();
    end

endmodule